// File: doc/BRIEF.md
# Banked Register Access Unit

This unit holds the copies of general registers and saved status words that belong to processor modes other than the one running. It also performs the moves that transfer one of those copies to or from a general register without a mode switch. A request names its target with a one-bit selector (`req_r`: general register when 0, saved status word when 1) and a five-bit select code (`req_sysm`). The unit decodes these into a target mode and a register class, and checks the access against the current mode, exception level, security state and enabled features. It then either carries out the transfer or reports the instruction as undefined, together with the exception level that should take the fault.

Each request lasts one cycle and always gets exactly one response in the next cycle. The response is either a completion strobe, which carries read data for a read, or an undefined flag with a target level. A denied request never changes stored state. Fetch, the main register file and exception entry are handled elsewhere.

Top module: `bank_access_unit`

## Requirements
- R1: After synchronous reset, `rsp_done`, `rsp_undef`, `rsp_undef_el` and `rsp_rdata` are zero and every banked register holds zero.
- R2: The cycle after a request (`req_valid`=1), exactly one of `rsp_done` or `rsp_undef` is high. With no request in a cycle, neither is high in the following cycle.
- R3: With `req_r`=1, select codes 0x0E, 0x10, 0x12, 0x14, 0x16, 0x1C and 0x1E address the saved status word of FIQ, IRQ, SVC, ABT, UND, MON and HYP respectively. Every other select code is undefined.
- R4: With `req_r`=0, codes 0x00 to 0x06 address user r8 to r14, and codes 0x08 to 0x0E address FIQ r8 to r14. These are fourteen separate registers.
- R5: With `req_r`=0, the pairs 0x10/0x11 (IRQ), 0x12/0x13 (SVC), 0x14/0x15 (ABT), 0x16/0x17 (UND) and 0x1C/0x1D (MON) address r14 when bit 0 is 0 and r13 when it is 1. Code 0x1E addresses the hypervisor exception link register and 0x1F addresses hypervisor r13. Codes 0x07, 0x0F and 0x18 to 0x1B are undefined.
- R6: A request is undefined if the current mode is user (0x10), if `req_reg` is 15, or if `feat_v8` and `feat_el2` are both 0.
- R7: A request is undefined when its target mode equals `cur_mode`. The mode encodings are USR 0x10, FIQ 0x11, IRQ 0x12, SVC 0x13, MON 0x16, ABT 0x17, HYP 0x1A, UND 0x1B and SYS 0x1F.
- R8: For user-mode targets, r8 to r12 are allowed only from FIQ mode. User r13 is refused from SYS mode, and user r14 is refused from HYP and SYS mode.
- R9: A hypervisor target is undefined unless `feat_el2`=1 and `cur_el`=3. The exception link register is then allowed only from HYP or MON mode, and the other hypervisor registers only from MON mode.
- R10: A monitor target is undefined when `feat_el3`=0 or `cur_secure`=0. Otherwise, when the request comes from `cur_el`=1, it is undefined with `rsp_undef_el`=3.
- R11: For every other undefined case, `rsp_undef_el` is 1 when `cur_el` is 0 or 1, and equals `cur_el` otherwise.
- R12: A write (`req_write`=1) that is allowed updates the register at the clock edge that accepts it, and its response carries `rsp_rdata`=0. A read returns the stored value in `rsp_rdata` together with `rsp_done`. A denied write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = move general register to banked copy, 0 = read banked copy |
| req_r | input | 1 | 1 selects a saved status word, 0 a general register |
| req_sysm | input | 5 | Select code for the banked register |
| req_reg | input | 4 | Source/destination general register index |
| req_wdata | input | 32 | Write data |
| cur_mode | input | 5 | Current processor mode |
| cur_el | input | 2 | Current exception level |
| cur_secure | input | 1 | Current state is secure |
| feat_v8 | input | 1 | v8 architecture feature enabled |
| feat_el2 | input | 1 | EL2 implemented |
| feat_el3 | input | 1 | EL3 implemented |
| rsp_done | output | 1 | Allowed request completed |
| rsp_undef | output | 1 | Request was undefined |
| rsp_undef_el | output | 2 | Exception level that takes the undefined fault |
| rsp_rdata | output | 32 | Read data, valid with `rsp_done` |

## Verification
Every result appears exactly one clock after the request that causes it. Both the completion or undefined flag and its read data or target level come from the same register stage, so a write followed directly by a read returns the new value on the second response. The driver pushes one expected entry for each request it issues on a falling edge. The monitor samples just after the next rising edge, when that request's response is due, so each entry is matched to its own cycle. A missing response and an unexpected one are both reported as failures.

// File: rtl/bank_pkg.sv
package bank_pkg;

    localparam int SYSM_W    = 5;
    localparam int MODE_W    = 5;
    localparam int EL_W      = 2;
    localparam int NUM_SLOTS = 33;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int PSR_BASE  = 26;

    typedef enum logic [MODE_W-1:0] {
        MODE_USR = 5'h10,
        MODE_FIQ = 5'h11,
        MODE_IRQ = 5'h12,
        MODE_SVC = 5'h13,
        MODE_MON = 5'h16,
        MODE_ABT = 5'h17,
        MODE_HYP = 5'h1A,
        MODE_UND = 5'h1B,
        MODE_SYS = 5'h1F
    } cpu_mode_e;

    typedef enum logic [2:0] {
        RK_LOW,
        RK_SP,
        RK_LR,
        RK_ELR,
        RK_PSR
    } reg_kind_e;

    typedef struct packed {
        logic              ok;
        cpu_mode_e         tgt;
        reg_kind_e         kind;
        logic [SLOT_W-1:0] slot;
    } bank_sel_t;

    // Target mode of the r13/r14 pair codes, indexed by sysm[4:1].
    function automatic cpu_mode_e pair_mode(logic [SYSM_W-2:0] hi);
        case (hi)
            4'h8:    return MODE_IRQ;
            4'h9:    return MODE_SVC;
            4'hA:    return MODE_ABT;
            4'hB:    return MODE_UND;
            4'hE:    return MODE_MON;
            default: return MODE_HYP;
        endcase
    endfunction

    // Register class of the r8..r14 codes, indexed by sysm[2:0].
    function automatic reg_kind_e low_kind(logic [2:0] lo);
        case (lo)
            3'd5:    return RK_SP;
            3'd6:    return RK_LR;
            default: return RK_LOW;
        endcase
    endfunction

    function automatic bank_sel_t decode_sel(logic r, logic [SYSM_W-1:0] sysm);
        bank_sel_t s;
        s      = '0;
        s.tgt  = MODE_USR;
        s.kind = RK_LOW;
        if (r) begin
            s.kind = RK_PSR;
            s.ok   = 1'b1;
            case (sysm)
                5'h0E: begin s.tgt = MODE_FIQ; s.slot = SLOT_W'(PSR_BASE + 0); end
                5'h10: begin s.tgt = MODE_IRQ; s.slot = SLOT_W'(PSR_BASE + 1); end
                5'h12: begin s.tgt = MODE_SVC; s.slot = SLOT_W'(PSR_BASE + 2); end
                5'h14: begin s.tgt = MODE_ABT; s.slot = SLOT_W'(PSR_BASE + 3); end
                5'h16: begin s.tgt = MODE_UND; s.slot = SLOT_W'(PSR_BASE + 4); end
                5'h1C: begin s.tgt = MODE_MON; s.slot = SLOT_W'(PSR_BASE + 5); end
                5'h1E: begin s.tgt = MODE_HYP; s.slot = SLOT_W'(PSR_BASE + 6); end
                default: s.ok = 1'b0;
            endcase
        end else begin
            if (sysm <= 5'h06) begin
                s.ok   = 1'b1;
                s.tgt  = MODE_USR;
                s.kind = low_kind(sysm[2:0]);
                s.slot = SLOT_W'(sysm);
            end else if (sysm >= 5'h08 && sysm <= 5'h0E) begin
                s.ok   = 1'b1;
                s.tgt  = MODE_FIQ;
                s.kind = low_kind(sysm[2:0]);
                s.slot = SLOT_W'(sysm) - SLOT_W'(1);
            end else if ((sysm >= 5'h10 && sysm <= 5'h17) || sysm >= 5'h1C) begin
                s.ok  = 1'b1;
                s.tgt = pair_mode(sysm[SYSM_W-1:1]);
                if (sysm[0])
                    s.kind = RK_SP;
                else if (s.tgt == MODE_HYP)
                    s.kind = RK_ELR;
                else
                    s.kind = RK_LR;
                if (sysm <= 5'h17)
                    s.slot = SLOT_W'(sysm) - SLOT_W'(2);
                else
                    s.slot = SLOT_W'(sysm) - SLOT_W'(6);
            end
        end
        return s;
    endfunction

    function automatic logic [EL_W-1:0] default_trap_el(logic [EL_W-1:0] el);
        return (el <= 2'd1) ? 2'd1 : el;
    endfunction

endpackage

// File: rtl/bank_decode.sv
module bank_decode
    import bank_pkg::*;
(
    input  logic              sel_r,
    input  logic [SYSM_W-1:0] sel_sysm,
    output bank_sel_t         sel
);
    always_comb begin
        sel = decode_sel(sel_r, sel_sysm);
    end
endmodule

// File: rtl/bank_permit.sv
module bank_permit
    import bank_pkg::*;
#(
    parameter int REG_IDX_W = 4
) (
    input  bank_sel_t             sel,
    input  logic [MODE_W-1:0]     cur_mode,
    input  logic [EL_W-1:0]       cur_el,
    input  logic                  cur_secure,
    input  logic                  feat_v8,
    input  logic                  feat_el2,
    input  logic                  feat_el3,
    input  logic [REG_IDX_W-1:0]  reg_idx,
    output logic                  deny,
    output logic [EL_W-1:0]       trap_el
);
    localparam logic [REG_IDX_W-1:0] PC_IDX = '1;

    logic static_fail;
    logic mon_trap;
    logic late_fail;
    logic usr_fail;
    logic hyp_fail;

    always_comb begin
        static_fail = (cur_mode == MODE_USR)
                    || (reg_idx == PC_IDX)
                    || !(feat_v8 || feat_el2)
                    || !sel.ok
                    || (sel.tgt == MODE_MON && (!feat_el3 || !cur_secure))
                    || (sel.tgt == MODE_HYP && (!feat_el2 || cur_el != 2'd3));

        mon_trap = !static_fail && (sel.tgt == MODE_MON) && (cur_el == 2'd1);

        usr_fail = 1'b0;
        if (sel.tgt == MODE_USR) begin
            case (sel.kind)
                RK_LOW:  usr_fail = (cur_mode != MODE_FIQ);
                RK_SP:   usr_fail = (cur_mode == MODE_SYS);
                RK_LR:   usr_fail = (cur_mode == MODE_HYP) || (cur_mode == MODE_SYS);
                default: usr_fail = 1'b0;
            endcase
        end

        hyp_fail = 1'b0;
        if (sel.tgt == MODE_HYP) begin
            if (sel.kind == RK_ELR)
                hyp_fail = (cur_mode != MODE_HYP) && (cur_mode != MODE_MON);
            else
                hyp_fail = (cur_mode != MODE_MON);
        end

        late_fail = (cur_mode == sel.tgt) || usr_fail || hyp_fail;

        deny    = static_fail || mon_trap || late_fail;
        trap_el = mon_trap ? 2'd3 : default_trap_el(cur_el);
    end
endmodule

// File: rtl/bank_store.sv
module bank_store
    import bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data
);
    logic [NUM_SLOTS-1:0][DATA_W-1:0] regs;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (wr_en && wr_slot == SLOT_W'(g))
                regs[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (rd_slot == SLOT_W'(i))
                rd_data = regs[i];
    end

    // R12: without a write strobe no banked register moves
    a_r12_store_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> (regs == $past(regs)));

    // R12: a write lands in the addressed slot at the accepting edge
    a_r12_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (regs[$past(wr_slot)] == $past(wr_data)));
endmodule

// File: rtl/bank_access_unit.sv
module bank_access_unit
    import bank_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_IDX_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_r,
    input  logic [4:0]           req_sysm,
    input  logic [REG_IDX_W-1:0] req_reg,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [4:0]           cur_mode,
    input  logic [1:0]           cur_el,
    input  logic                 cur_secure,
    input  logic                 feat_v8,
    input  logic                 feat_el2,
    input  logic                 feat_el3,
    output logic                 rsp_done,
    output logic                 rsp_undef,
    output logic [1:0]           rsp_undef_el,
    output logic [DATA_W-1:0]    rsp_rdata
);
    bank_sel_t         sel;
    logic              deny;
    logic [EL_W-1:0]   trap_el;
    logic              store_we;
    logic [DATA_W-1:0] store_rd;

    bank_decode u_decode (
        .sel_r    (req_r),
        .sel_sysm (req_sysm),
        .sel      (sel)
    );

    bank_permit #(.REG_IDX_W(REG_IDX_W)) u_permit (
        .sel        (sel),
        .cur_mode   (cur_mode),
        .cur_el     (cur_el),
        .cur_secure (cur_secure),
        .feat_v8    (feat_v8),
        .feat_el2   (feat_el2),
        .feat_el3   (feat_el3),
        .reg_idx    (req_reg),
        .deny       (deny),
        .trap_el    (trap_el)
    );

    assign store_we = req_valid && req_write && !deny;

    bank_store #(.DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (store_we),
        .wr_slot (sel.slot),
        .wr_data (req_wdata),
        .rd_slot (sel.slot),
        .rd_data (store_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done     <= 1'b0;
            rsp_undef    <= 1'b0;
            rsp_undef_el <= '0;
            rsp_rdata    <= '0;
        end else begin
            rsp_done     <= req_valid && !deny;
            rsp_undef    <= req_valid && deny;
            rsp_undef_el <= (req_valid && deny) ? trap_el : 2'd0;
            rsp_rdata    <= (req_valid && !deny && !req_write) ? store_rd : '0;
        end
    end

    // R2: a single response per request, in the following cycle
    a_r2_one_response: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_done ^ rsp_undef));

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !(rsp_done || rsp_undef));

    // R6: user-mode requests are always refused
    a_r6_user_refused: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cur_mode == MODE_USR) |=> rsp_undef);

    // R7: targeting the running mode is refused
    a_r7_same_mode: assert property (@(posedge clk) disable iff (rst)
        (req_valid && sel.ok && cur_mode == sel.tgt) |=> rsp_undef);

    // R10: a level-3 fault from EL1 only arises for a secure monitor access
    a_r10_el3_trap_secure: assert property (@(posedge clk) disable iff (rst)
        (rsp_undef && rsp_undef_el == 2'd3 && $past(cur_el) == 2'd1)
            |-> ($past(cur_secure) && $past(feat_el3)));

    // R11: fault level never below EL1
    a_r11_el_floor: assert property (@(posedge clk) disable iff (rst)
        rsp_undef |-> (rsp_undef_el != 2'd0));
endmodule

// File: tb/bank_access_unit_test.sv
module bank_access_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12,
                           M_SVC = 5'h13, M_MON = 5'h16, M_HYP = 5'h1A,
                           M_SYS = 5'h1F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_r = 1'b0;
    logic [4:0]  req_sysm = '0;
    logic [3:0]  req_reg = 4'd2;
    logic [31:0] req_wdata = '0;
    logic [4:0]  cur_mode = 5'h13;
    logic [1:0]  cur_el = 2'd1;
    logic        cur_secure = 1'b0;
    logic        feat_v8 = 1'b1, feat_el2 = 1'b1, feat_el3 = 1'b1;
    logic        rsp_done, rsp_undef;
    logic [1:0]  rsp_undef_el;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        bit          undef;
        logic [1:0]  el;
        logic [31:0] data;
        string       tag;
    } exp_t;
    exp_t expq[$];

    bank_access_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_r(req_r), .req_sysm(req_sysm), .req_reg(req_reg),
        .req_wdata(req_wdata), .cur_mode(cur_mode), .cur_el(cur_el),
        .cur_secure(cur_secure), .feat_v8(feat_v8), .feat_el2(feat_el2),
        .feat_el3(feat_el3), .rsp_done(rsp_done), .rsp_undef(rsp_undef),
        .rsp_undef_el(rsp_undef_el), .rsp_rdata(rsp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic ctx(input logic [4:0] m, input logic [1:0] el, input logic sec);
        cur_mode = m; cur_el = el; cur_secure = sec;
    endtask

    task automatic issue(input bit wr, input bit r, input logic [4:0] sysm,
                         input logic [3:0] idx, input logic [31:0] wd,
                         input bit eu, input logic [1:0] eel,
                         input logic [31:0] ed, input string tag);
        exp_t e;
        req_valid = 1'b1; req_write = wr; req_r = r; req_sysm = sysm;
        req_reg = idx; req_wdata = wd;
        e.undef = eu; e.el = eel; e.data = wr ? 32'h0 : ed; e.tag = tag;
        expq.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input bit r, input logic [4:0] s, input bit eu,
                      input logic [1:0] eel, input logic [31:0] ed, input string tag);
        issue(1'b0, r, s, 4'd2, 32'h0, eu, eel, ed, tag);
    endtask

    task automatic wr(input bit r, input logic [4:0] s, input logic [31:0] d,
                      input bit eu, input logic [1:0] eel, input string tag);
        issue(1'b1, r, s, 4'd3, d, eu, eel, 32'h0, tag);
    endtask

    // Monitor: compares each response against the oldest expected item
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst) begin
                if (expq.size() > 0) begin
                    exp_t e;
                    e = expq.pop_front();
                    checks++;
                    if (rsp_done == rsp_undef) begin
                        errors++;
                        $display("FAIL %s: done=%0b undef=%0b expected undef=%0b",
                                 e.tag, rsp_done, rsp_undef, e.undef);
                    end else if (e.undef && (!rsp_undef || rsp_undef_el != e.el)) begin
                        errors++;
                        $display("FAIL %s: undef=%0b el=%0d expected undef=1 el=%0d",
                                 e.tag, rsp_undef, rsp_undef_el, e.el);
                    end else if (!e.undef && (!rsp_done || rsp_rdata !== e.data)) begin
                        errors++;
                        $display("FAIL %s: done=%0b rdata=%h expected done=1 rdata=%h",
                                 e.tag, rsp_done, rsp_rdata, e.data);
                    end
                end else if (rsp_done || rsp_undef) begin
                    checks++; errors++;
                    $display("FAIL R2: response done=%0b undef=%0b expected none",
                             rsp_done, rsp_undef);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_done || rsp_undef || rsp_undef_el != 0 || rsp_rdata != 0) begin
            errors++;
            $display("FAIL R1: outputs in reset %0b %0b %0d %h expected all zero",
                     rsp_done, rsp_undef, rsp_undef_el, rsp_rdata);
        end
        rst = 1'b0;
        @(negedge clk);

        // R1: stored registers start at zero
        ctx(M_FIQ, 2'd1, 1'b0);
        rd(0, 5'h00, 0, 0, 32'h0, "R1 usr r8 reset value");
        ctx(M_SVC, 2'd1, 1'b0);
        rd(1, 5'h0E, 0, 0, 32'h0, "R1 fiq psr reset value");

        // R4 user/fiq low banks
        ctx(M_FIQ, 2'd1, 1'b0);
        wr(0, 5'h00, 32'h0000_00A5, 0, 0, "R12 write usr r8");
        rd(0, 5'h00, 0, 0, 32'h0000_00A5, "R4 read usr r8");
        wr(0, 5'h04, 32'h0000_0C12, 0, 0, "R4 write usr r12");
        ctx(M_SVC, 2'd1, 1'b0);
        wr(0, 5'h05, 32'h0000_1111, 0, 0, "R4 write usr r13");
        wr(0, 5'h0D, 32'h0000_2222, 0, 0, "R4 write fiq r13");
        wr(0, 5'h08, 32'h0000_F008, 0, 0, "R4 write fiq r8");
        rd(0, 5'h05, 0, 0, 32'h0000_1111, "R4 usr r13 separate from fiq");
        rd(0, 5'h0D, 0, 0, 32'h0000_2222, "R4 fiq r13");
        rd(0, 5'h08, 0, 0, 32'h0000_F008, "R4 fiq r8");
        rd(0, 5'h06, 0, 0, 32'h0, "R4 usr r14 untouched");
        ctx(M_FIQ, 2'd1, 1'b0);
        rd(0, 5'h04, 0, 0, 32'h0000_0C12, "R4 usr r12");

        // R5 pairs
        ctx(M_SVC, 2'd1, 1'b0);
        wr(0, 5'h10, 32'h0000_3333, 0, 0, "R5 write irq r14");
        wr(0, 5'h11, 32'h0000_4444, 0, 0, "R5 write irq r13");
        rd(0, 5'h10, 0, 0, 32'h0000_3333, "R5 irq r14");
        rd(0, 5'h11, 0, 0, 32'h0000_4444, "R5 irq r13");
        wr(0, 5'h17, 32'h0000_5757, 0, 0, "R5 write und r13");
        rd(0, 5'h17, 0, 0, 32'h0000_5757, "R5 und r13");
        rd(0, 5'h07, 1, 1, 32'h0, "R5 code 0x07 unallocated");
        rd(0, 5'h0F, 1, 1, 32'h0, "R5 code 0x0F unallocated");
        rd(0, 5'h18, 1, 1, 32'h0, "R5 code 0x18 unallocated");
        rd(0, 5'h1B, 1, 1, 32'h0, "R5 code 0x1B unallocated");

        // R3 saved status words
        wr(1, 5'h0E, 32'h0000_5555, 0, 0, "R3 write fiq psr");
        wr(1, 5'h16, 32'h0000_6161, 0, 0, "R3 write und psr");
        rd(1, 5'h0E, 0, 0, 32'h0000_5555, "R3 fiq psr");
        rd(1, 5'h16, 0, 0, 32'h0000_6161, "R3 und psr");
        rd(1, 5'h11, 1, 1, 32'h0, "R3 code 0x11 undefined");
        rd(1, 5'h00, 1, 1, 32'h0, "R3 code 0x00 undefined");

        // R7 same mode
        rd(1, 5'h12, 1, 1, 32'h0, "R7 svc psr from svc");
        wr(0, 5'h13, 32'hBAD0_0013, 1, 1, "R7 svc r13 from svc");
        ctx(M_FIQ, 2'd1, 1'b0);
        rd(0, 5'h08, 1, 1, 32'h0, "R7 fiq r8 from fiq");

        // R6 gates
        ctx(M_USR, 2'd0, 1'b0);
        rd(0, 5'h10, 1, 1, 32'h0, "R6 from user mode");
        ctx(M_SVC, 2'd1, 1'b0);
        issue(0, 0, 5'h10, 4'd15, 32'h0, 1, 1, 32'h0, "R6 register index 15");
        feat_v8 = 1'b0; feat_el2 = 1'b0;
        rd(0, 5'h10, 1, 1, 32'h0, "R6 both features off");
        feat_el2 = 1'b1;
        rd(0, 5'h10, 0, 0, 32'h0000_3333, "R6 el2 alone enables");
        feat_v8 = 1'b1;

        // R8 user target restrictions
        rd(0, 5'h00, 1, 1, 32'h0, "R8 usr r8 from svc");
        ctx(M_SYS, 2'd1, 1'b0);
        rd(0, 5'h05, 1, 1, 32'h0, "R8 usr r13 from sys");
        rd(0, 5'h06, 1, 1, 32'h0, "R8 usr r14 from sys");
        ctx(M_HYP, 2'd2, 1'b0);
        rd(0, 5'h06, 1, 2, 32'h0, "R8 usr r14 from hyp (R11 level 2)");
        rd(0, 5'h05, 0, 0, 32'h0000_1111, "R8 usr r13 from hyp allowed");

        // R10 monitor target
        ctx(M_SVC, 2'd1, 1'b0);
        rd(0, 5'h1C, 1, 1, 32'h0, "R10 monitor non-secure");
        feat_el3 = 1'b0;
        ctx(M_SVC, 2'd1, 1'b1);
        rd(0, 5'h1C, 1, 1, 32'h0, "R10 monitor without el3");
        feat_el3 = 1'b1;
        rd(0, 5'h1C, 1, 3, 32'h0, "R10 secure el1 traps to level 3");
        ctx(M_SVC, 2'd3, 1'b1);
        wr(0, 5'h1C, 32'h0000_6666, 0, 0, "R10 write mon r14 at el3");
        rd(0, 5'h1C, 0, 0, 32'h0000_6666, "R10 mon r14");

        // R9 hypervisor target
        ctx(M_MON, 2'd3, 1'b1);
        wr(0, 5'h1E, 32'h0000_7777, 0, 0, "R9 write elr from mon");
        wr(0, 5'h1F, 32'h0000_8888, 0, 0, "R9 write hyp r13 from mon");
        wr(1, 5'h1E, 32'h0000_9999, 0, 0, "R9 write hyp psr from mon");
        rd(0, 5'h1E, 0, 0, 32'h0000_7777, "R9 elr");
        rd(0, 5'h1F, 0, 0, 32'h0000_8888, "R9 hyp r13");
        rd(1, 5'h1E, 0, 0, 32'h0000_9999, "R9 hyp psr");
        ctx(M_SVC, 2'd3, 1'b1);
        rd(0, 5'h1E, 1, 3, 32'h0, "R9 elr from svc");
        ctx(M_SVC, 2'd1, 1'b0);
        rd(0, 5'h1F, 1, 1, 32'h0, "R9 hyp r13 below el3");
        ctx(M_MON, 2'd3, 1'b1);
        feat_el2 = 1'b0;
        rd(0, 5'h1F, 1, 3, 32'h0, "R9 hyp r13 without el2");
        feat_el2 = 1'b1;

        // R12 denied writes leave state intact
        ctx(M_SVC, 2'd1, 1'b0);
        wr(0, 5'h00, 32'hDEAD_BEEF, 1, 1, "R12 denied usr r8 write");
        ctx(M_FIQ, 2'd1, 1'b0);
        rd(0, 5'h00, 0, 0, 32'h0000_00A5, "R12 usr r8 kept");
        ctx(M_IRQ, 2'd1, 1'b0);
        rd(0, 5'h13, 0, 0, 32'h0, "R12 svc r13 kept after denied write");

        req_valid = 1'b0;
        repeat (4) @(negedge clk);
        if (expq.size() != 0) begin
            checks++; errors++;
            $display("FAIL R2: %0d responses missing, expected 0", expq.size());
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule